// File: doc/BRIEF.md
# Synchronous Serial Port Register Front End

This block is the bus-facing register file of a synchronous serial port. A host reaches it through a plain single-cycle read/write bus with a 12-bit word-aligned offset. The block keeps the frame-format control word, the enable and mode control word, the clock prescaler and the interrupt enable mask. It forwards the data-port accesses to a separate transfer engine, which owns the transmit and receive FIFOs.

The transfer engine reports how many words each FIFO holds. From these two counts the block derives the status word, the raw and masked interrupt flags, and one level-sensitive interrupt line. All of them are combinational. Reads are also combinational: `rdata` is valid in the same cycle that `rdEn` and `addr` are presented. Register writes take effect at the next rising clock edge.

The top 32 bytes of the window hold a fixed table of identification bytes. The DMA control location always reads as zero.

Top module: `serport_regfile`

## Requirements
- R1: After reset, the control 0, control 1, prescaler and mask registers are zero. With both FIFO counts at zero, status reads 0x03 and raw interrupt status reads 0x08.
- R2: A write to offset 0x00 stores the low 16 bits, a write to 0x04 stores the low 4 bits, and a write to 0x14 stores the low 4 bits of the mask. Each of them reads back what was stored, with zeros above.
- R3: A write to the prescaler at offset 0x10 keeps only bits 7:0, and a read returns them with bits 31:8 zero.
- R4: Status is read at offset 0x0C, and only bits 4:0 can be set:
  - bit 0 is 1 when the transmit count is 0;
  - bit 1 is 1 when the transmit count is not 8;
  - bit 2 is 1 when the receive count is not 0;
  - bit 3 is 1 when the receive count is 8;
  - bit 4 (busy) is 1 when the transmit count is not 0.
- R5: Raw interrupt status is read at offset 0x18. Bit 2 is 1 when the receive count is 4 or more, bit 3 is 1 when the transmit count is 4 or less, and all other bits are 0.
- R6: Masked status at offset 0x1C reads as mask AND raw. `irq` is high exactly when that value is non-zero.
- R7: Reads at 0xFE0, 0xFE4 and so on up to 0xFFC return, in address order, the bytes 0x22, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05 and 0xB1 in bits 7:0, with all higher bits zero.
- R8: A read at offset 0x20 returns zero, and so does a read at an undefined offset. Writes to 0x0C, 0x18, 0x1C, 0x20, the identification region and undefined offsets leave every register unchanged.
- R9: A write to offset 0x08 pulses `txPush` for that cycle only when the transmit count is below 8. The pushed word is `wdata` masked to the frame size, which is the control 0 bits 3:0 value plus one bits.
- R10: A read at offset 0x08 pulses `rxPop` and returns `rxData` when the receive count is non-zero. When the receive count is zero it returns zero and `rxPop` stays low.
- R11: Status, raw status, masked status and `irq` follow a change of the FIFO counts in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | 12 | Byte offset, word aligned |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational |
| txCount | input | 4 | Words held in the transmit FIFO (0..8) |
| rxCount | input | 4 | Words held in the receive FIFO (0..8) |
| rxData | input | 16 | Head word of the receive FIFO |
| txPush | output | 1 | Push request to the transmit FIFO |
| txPushData | output | 16 | Word to push, masked to the frame size |
| rxPop | output | 1 | Pop request to the receive FIFO |
| ctrl0 | output | 16 | Frame format control to the engine |
| ctrl1 | output | 4 | Enable and mode control to the engine |
| prescale | output | 8 | Clock prescaler to the engine |
| irq | output | 1 | Level interrupt |

## Verification
The hardest situations to produce are the edges of the FIFO counts: exactly 4 words, where both half-level interrupt flags can be true at once, and a full transmit FIFO, where a data write must be dropped. In a real system these only occur after long transfers. Here the bench drives the counts directly, so it can hold them at 0, 4 and 8 while it writes, reads and changes the mask. A seeded random phase then mixes count values, mask values and register accesses, so that `irq` is checked under many mask and flag combinations.

// File: rtl/serport_pkg.sv
package serport_pkg;

  localparam int OFF_CTRL0 = 'h00;
  localparam int OFF_CTRL1 = 'h04;
  localparam int OFF_DATA  = 'h08;
  localparam int OFF_STAT  = 'h0C;
  localparam int OFF_PRESC = 'h10;
  localparam int OFF_MASK  = 'h14;
  localparam int OFF_RAW   = 'h18;
  localparam int OFF_MIS   = 'h1C;
  localparam int OFF_DMA   = 'h20;

  typedef enum logic [3:0] {
    SEL_CTRL0, SEL_CTRL1, SEL_DATA, SEL_STAT, SEL_PRESC,
    SEL_MASK, SEL_RAW, SEL_MIS, SEL_DMA, SEL_ID, SEL_NONE
  } regSel_e;

  typedef struct packed {
    logic     wrCtrl0;
    logic     wrCtrl1;
    logic     wrPresc;
    logic     wrMask;
    logic     wrData;
    logic     rdData;
    regSel_e  rdSel;
    logic [2:0] idIdx;
  } regStrobe_t;

  function automatic logic [7:0] idByte(input logic [2:0] idx);
    case (idx)
      3'd0: idByte = 8'h22;
      3'd1: idByte = 8'h10;
      3'd2: idByte = 8'h04;
      3'd3: idByte = 8'h00;
      3'd4: idByte = 8'h0D;
      3'd5: idByte = 8'hF0;
      3'd6: idByte = 8'h05;
      default: idByte = 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/serport_ctrl.sv
module serport_ctrl
  import serport_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output regStrobe_t        strb
);

  localparam int ID_LSB = 5;

  regSel_e sel;

  always_comb begin
    sel = SEL_NONE;
    if (addr[1:0] == 2'b00) begin
      if (&addr[ADDR_W-1:ID_LSB]) begin
        sel = SEL_ID;
      end else begin
        case (addr)
          ADDR_W'(OFF_CTRL0): sel = SEL_CTRL0;
          ADDR_W'(OFF_CTRL1): sel = SEL_CTRL1;
          ADDR_W'(OFF_DATA):  sel = SEL_DATA;
          ADDR_W'(OFF_STAT):  sel = SEL_STAT;
          ADDR_W'(OFF_PRESC): sel = SEL_PRESC;
          ADDR_W'(OFF_MASK):  sel = SEL_MASK;
          ADDR_W'(OFF_RAW):   sel = SEL_RAW;
          ADDR_W'(OFF_MIS):   sel = SEL_MIS;
          ADDR_W'(OFF_DMA):   sel = SEL_DMA;
          default:            sel = SEL_NONE;
        endcase
      end
    end
  end

  always_comb begin
    strb.wrCtrl0 = wrEn && (sel == SEL_CTRL0);
    strb.wrCtrl1 = wrEn && (sel == SEL_CTRL1);
    strb.wrPresc = wrEn && (sel == SEL_PRESC);
    strb.wrMask  = wrEn && (sel == SEL_MASK);
    strb.wrData  = wrEn && (sel == SEL_DATA);
    strb.rdData  = rdEn && (sel == SEL_DATA);
    strb.rdSel   = rdEn ? sel : SEL_NONE;
    strb.idIdx   = addr[4:2];
  end

endmodule

// File: rtl/serport_dpath.sv
module serport_dpath
  import serport_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int DEPTH   = 8,
  parameter int CTRL1_W = 4,
  parameter int PRESC_W = 8,
  parameter int MASK_W  = 4,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int SIZE_W = $clog2(DATA_W)
) (
  input  logic               clk,
  input  logic               rstN,
  input  regStrobe_t         strb,
  input  logic [31:0]        wdata,
  input  logic [CNT_W-1:0]   txCount,
  input  logic [CNT_W-1:0]   rxCount,
  input  logic [DATA_W-1:0]  rxData,
  output logic [31:0]        rdata,
  output logic               txPush,
  output logic [DATA_W-1:0]  txPushData,
  output logic               rxPop,
  output logic               irq,
  output logic [DATA_W-1:0]  ctrl0Q,
  output logic [CTRL1_W-1:0] ctrl1Q,
  output logic [PRESC_W-1:0] prescQ
);

  localparam int HALF = DEPTH / 2;

  logic [MASK_W-1:0] maskQ;
  logic [4:0]        statBits;
  logic [MASK_W-1:0] rawBits;
  logic [MASK_W-1:0] misBits;
  logic [DATA_W-1:0] frameMask;
  logic              txFull;
  logic              rxEmpty;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrl0Q <= '0;
      ctrl1Q <= '0;
      prescQ <= '0;
      maskQ  <= '0;
    end else begin
      if (strb.wrCtrl0) ctrl0Q <= wdata[DATA_W-1:0];
      if (strb.wrCtrl1) ctrl1Q <= wdata[CTRL1_W-1:0];
      if (strb.wrPresc) prescQ <= wdata[PRESC_W-1:0];
      if (strb.wrMask)  maskQ  <= wdata[MASK_W-1:0];
    end
  end

  assign txFull  = (txCount == CNT_W'(DEPTH));
  assign rxEmpty = (rxCount == '0);

  always_comb begin
    statBits[0] = (txCount == '0);
    statBits[1] = !txFull;
    statBits[2] = !rxEmpty;
    statBits[3] = (rxCount == CNT_W'(DEPTH));
    statBits[4] = (txCount != '0);
  end

  always_comb begin
    rawBits    = '0;
    rawBits[2] = (rxCount >= CNT_W'(HALF));
    rawBits[3] = (txCount <= CNT_W'(HALF));
  end

  assign misBits = maskQ & rawBits;
  assign irq     = |misBits;

  for (genvar i = 0; i < DATA_W; i++) begin : g_frame
    assign frameMask[i] = (ctrl0Q[SIZE_W-1:0] >= SIZE_W'(i));
  end

  assign txPush     = strb.wrData && !txFull;
  assign txPushData = wdata[DATA_W-1:0] & frameMask;
  assign rxPop      = strb.rdData && !rxEmpty;

  always_comb begin
    rdata = '0;
    case (strb.rdSel)
      SEL_CTRL0: rdata = 32'(ctrl0Q);
      SEL_CTRL1: rdata = 32'(ctrl1Q);
      SEL_DATA:  rdata = rxEmpty ? '0 : 32'(rxData);
      SEL_STAT:  rdata = 32'(statBits);
      SEL_PRESC: rdata = 32'(prescQ);
      SEL_MASK:  rdata = 32'(maskQ);
      SEL_RAW:   rdata = 32'(rawBits);
      SEL_MIS:   rdata = 32'(misBits);
      SEL_ID:    rdata = 32'(idByte(strb.idIdx));
      default:   rdata = '0;
    endcase
  end

endmodule

// File: rtl/serport_regfile.sv
module serport_regfile
  import serport_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 16,
  parameter int DEPTH   = 8,
  parameter int CTRL1_W = 4,
  parameter int PRESC_W = 8,
  parameter int MASK_W  = 4,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  input  logic [CNT_W-1:0]   txCount,
  input  logic [CNT_W-1:0]   rxCount,
  input  logic [DATA_W-1:0]  rxData,
  output logic               txPush,
  output logic [DATA_W-1:0]  txPushData,
  output logic               rxPop,
  output logic [DATA_W-1:0]  ctrl0,
  output logic [CTRL1_W-1:0] ctrl1,
  output logic [PRESC_W-1:0] prescale,
  output logic               irq
);

  regStrobe_t strb;

  serport_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .wrEn (wrEn),
    .rdEn (rdEn),
    .addr (addr),
    .strb (strb)
  );

  serport_dpath #(
    .DATA_W (DATA_W), .DEPTH (DEPTH), .CTRL1_W(CTRL1_W),
    .PRESC_W(PRESC_W), .MASK_W(MASK_W)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wdata      (wdata),
    .txCount    (txCount),
    .rxCount    (rxCount),
    .rxData     (rxData),
    .rdata      (rdata),
    .txPush     (txPush),
    .txPushData (txPushData),
    .rxPop      (rxPop),
    .irq        (irq),
    .ctrl0Q     (ctrl0),
    .ctrl1Q     (ctrl1),
    .prescQ     (prescale)
  );

endmodule

// File: rtl/serport_chk.sv
module serport_chk #(
  parameter int ADDR_W = 12,
  parameter int DEPTH  = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       rdata,
  input logic [CNT_W-1:0]  txCount,
  input logic [CNT_W-1:0]  rxCount,
  input logic              txPush,
  input logic              rxPop,
  input logic              irq,
  input logic [7:0]        prescale
);

  AST_MIS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == ADDR_W'('h1C)) |-> (irq == (rdata != 0))); // R6

  AST_PRESC_NARROW: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == ADDR_W'('h10)) |-> (rdata[31:8] == '0)); // R3

  AST_DMA_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == ADDR_W'('h20)) |-> (rdata == '0)); // R8

  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rstN)
    txPush |-> (wrEn && txCount != CNT_W'(DEPTH))); // R9

  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    rxPop |-> (rdEn && rxCount != '0)); // R10

  AST_STAT_NOTFULL: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == ADDR_W'('h0C)) |-> (rdata[1] == (txCount != CNT_W'(DEPTH)))); // R4

  AST_PRESC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && addr == ADDR_W'('h10)) |=> $stable(prescale)); // R8

endmodule

bind serport_regfile serport_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .rdEn     (rdEn),
  .addr     (addr),
  .rdata    (rdata),
  .txCount  (txCount),
  .rxCount  (rxCount),
  .txPush   (txPush),
  .rxPop    (rxPop),
  .irq      (irq),
  .prescale (prescale)
);

// File: tb/test_serport_regfile.sv
module test_serport_regfile;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  txCount = '0;
  logic [3:0]  rxCount = '0;
  logic [15:0] rxData = '0;
  logic        txPush;
  logic [15:0] txPushData;
  logic        rxPop;
  logic [15:0] ctrl0;
  logic [3:0]  ctrl1;
  logic [7:0]  prescale;
  logic        irq;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  logic [15:0] c0M = '0;
  logic [3:0]  c1M = '0;
  logic [7:0]  psM = '0;
  logic [3:0]  mkM = '0;

  always #10 clk = ~clk;

  serport_regfile i_serport_regfile (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wdata(wdata), .rdata(rdata), .txCount(txCount), .rxCount(rxCount),
    .rxData(rxData), .txPush(txPush), .txPushData(txPushData), .rxPop(rxPop),
    .ctrl0(ctrl0), .ctrl1(ctrl1), .prescale(prescale), .irq(irq)
  );

  function automatic logic [31:0] expStat(logic [3:0] t, logic [3:0] r);
    logic [31:0] v = '0;
    v[0] = (t == 0); v[1] = (t != 8); v[2] = (r != 0);
    v[3] = (r == 8); v[4] = (t != 0);
    return v;
  endfunction

  function automatic logic [31:0] expRaw(logic [3:0] t, logic [3:0] r);
    logic [31:0] v = '0;
    v[2] = (r >= 4); v[3] = (t <= 4);
    return v;
  endfunction

  function automatic logic [31:0] expId(int k);
    logic [7:0] tbl [8] = '{8'h22, 8'h10, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    return 32'(tbl[k]);
  endfunction

  function automatic logic [31:0] expRead(logic [11:0] a);
    if (a >= 12'hFE0 && a[1:0] == 0) return expId(int'(a[4:2]));
    case (a)
      12'h000: return 32'(c0M);
      12'h004: return 32'(c1M);
      12'h008: return (rxCount != 0) ? 32'(rxData) : 32'h0;
      12'h00C: return expStat(txCount, rxCount);
      12'h010: return 32'(psM);
      12'h014: return 32'(mkM);
      12'h018: return expRaw(txCount, rxCount);
      12'h01C: return 32'(mkM) & expRaw(txCount, rxCount);
      default: return 32'h0;
    endcase
  endfunction

  function automatic string reqOf(logic [11:0] a);
    if (a >= 12'hFE0) return "R7";
    case (a)
      12'h000, 12'h004, 12'h014: return "R2";
      12'h008: return "R10";
      12'h00C: return "R4";
      12'h010: return "R3";
      12'h018: return "R5";
      12'h01C: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic regWrite(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wrEn = 1'b1;
    @(posedge clk);
    #1 wrEn = 1'b0;
    case (a)
      12'h000: c0M = d[15:0];
      12'h004: c1M = d[3:0];
      12'h010: psM = d[7:0];
      12'h014: mkM = d[3:0];
      default: ;
    endcase
  endtask

  task automatic readCheck(logic [11:0] a, string req);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    #2 check(req, rdata, expRead(a));
    @(posedge clk);
    #1 rdEn = 1'b0;
  endtask

  task automatic setCounts(logic [3:0] t, logic [3:0] r);
    @(negedge clk);
    txCount = t; rxCount = r;
  endtask

  initial begin
    #2000000;
    nFails++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [11:0] addrs [14] = '{12'h000, 12'h004, 12'h008, 12'h00C, 12'h010,
      12'h014, 12'h018, 12'h01C, 12'h020, 12'h024, 12'h7F0, 12'hFE0, 12'hFEC, 12'hFFC};
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    readCheck(12'h00C, "R1");
    readCheck(12'h018, "R1");
    readCheck(12'h014, "R1");
    readCheck(12'h000, "R1");
    readCheck(12'h010, "R1");
    check("R1", 32'(irq), 32'h0);

    // R2 / R3 register widths
    regWrite(12'h000, 32'hDEAD_BEEF); readCheck(12'h000, "R2");
    check("R2", 32'(ctrl0), 32'h0000_BEEF);
    regWrite(12'h004, 32'hFFFF_FFFF); readCheck(12'h004, "R2");
    regWrite(12'h010, 32'h1234_56A5); readCheck(12'h010, "R3");
    check("R3", 32'(prescale), 32'h0000_00A5);

    // R7 identification table
    for (int k = 0; k < 8; k++) readCheck(12'hFE0 + 12'(4 * k), "R7");

    // R8 read-only and undefined writes ignored
    regWrite(12'h00C, 32'hFFFF_FFFF);
    regWrite(12'h018, 32'hFFFF_FFFF);
    regWrite(12'h020, 32'hFFFF_FFFF);
    regWrite(12'hFE0, 32'hFFFF_FFFF);
    regWrite(12'h030, 32'hFFFF_FFFF);
    readCheck(12'h000, "R8"); readCheck(12'h004, "R8");
    readCheck(12'h010, "R8"); readCheck(12'h014, "R8");
    readCheck(12'h020, "R8"); readCheck(12'h02C, "R8");

    // R4 / R5 / R11 thresholds at 0, 4, 8 and same-cycle follow
    for (int t = 0; t <= 8; t += 4) begin
      for (int r = 0; r <= 8; r += 4) begin
        setCounts(4'(t), 4'(r));
        #2 ;
        readCheck(12'h00C, "R4");
        readCheck(12'h018, "R5");
      end
    end
    setCounts(4'd3, 4'd5);
    @(negedge clk); addr = 12'h018; rdEn = 1'b1;
    #1 txCount = 4'd5; rxCount = 4'd3;
    #1 check("R11", rdata, 32'h0);
    @(posedge clk); #1 rdEn = 1'b0;

    // R6 masked status and irq
    regWrite(12'h014, 32'h0000_0004);
    setCounts(4'd8, 4'd4);
    #2 check("R6", 32'(irq), 32'h1);
    readCheck(12'h01C, "R6");
    setCounts(4'd8, 4'd3);
    #2 check("R6", 32'(irq), 32'h0);
    regWrite(12'h014, 32'h0000_0008);
    setCounts(4'd4, 4'd0);
    #2 check("R6", 32'(irq), 32'h1);

    // R9 data writes and frame masking
    regWrite(12'h000, 32'h0000_0007);
    setCounts(4'd7, 4'd0);
    @(negedge clk); addr = 12'h008; wdata = 32'h0000_ABCD; wrEn = 1'b1;
    #2 check("R9", 32'(txPush), 32'h1);
    check("R9", 32'(txPushData), 32'h0000_00CD);
    @(posedge clk); #1 wrEn = 1'b0;
    setCounts(4'd8, 4'd0);
    @(negedge clk); addr = 12'h008; wdata = 32'h0000_1111; wrEn = 1'b1;
    #2 check("R9", 32'(txPush), 32'h0);
    @(posedge clk); #1 wrEn = 1'b0;
    regWrite(12'h000, 32'h0000_000F);
    setCounts(4'd0, 4'd0);
    @(negedge clk); addr = 12'h008; wdata = 32'h0001_F00F; wrEn = 1'b1;
    #2 check("R9", 32'(txPushData), 32'h0000_F00F);
    @(posedge clk); #1 wrEn = 1'b0;

    // R10 data reads
    rxData = 16'h5A3C;
    setCounts(4'd0, 4'd2);
    @(negedge clk); addr = 12'h008; rdEn = 1'b1;
    #2 check("R10", rdata, 32'h0000_5A3C);
    check("R10", 32'(rxPop), 32'h1);
    @(posedge clk); #1 rdEn = 1'b0;
    setCounts(4'd0, 4'd0);
    @(negedge clk); addr = 12'h008; rdEn = 1'b1;
    #2 check("R10", rdata, 32'h0);
    check("R10", 32'(rxPop), 32'h0);
    @(posedge clk); #1 rdEn = 1'b0;

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [11:0] a = addrs[$urandom_range(0, 13)];
      setCounts(4'($urandom_range(0, 8)), 4'($urandom_range(0, 8)));
      rxData = 16'($urandom);
      if ($urandom_range(0, 2) == 0) regWrite(a, $urandom);
      else readCheck(a, reqOf(a));
      #2 check("R6", 32'(irq), 32'(|(mkM & expRaw(txCount, rxCount)[3:0])));
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule